// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects interrupt requests from a set of primary sources and from a second, subordinate group of sources, and presents a single active-high request line to the processor. The subordinate group is folded into primary channel 0, so one primary channel stands for a whole second tier of peripherals. Each source latches a pending flag on its rising edge. The flag stays set until software clears it. A per-channel enable mask decides which pending flags count toward the processor request.

Software reaches the block through a plain 32-bit register bus. Writes take effect on the clock edge at which `wr_en` is sampled. Reads are registered: `rdata` carries the value one edge after `rd_en` is sampled. The primary state is spread over as many 32-bit banks as the channel count needs, and each bank sits 4 bytes above the one before it. Enables are never written as a whole word. Software writes ones to a set address or to a clear address, so no read-modify-write is needed. A priority index register gives the number of the lowest-numbered primary channel that is pending and enabled. A read-only table returns the identity channel mapping.

Top module: `casc_irq_ctrl`

## Requirements
- R1: Reset has these effects. Every pending flag and every enable is 0. `irq_out` is 0. The index register reads 0x3F.
- R2: A primary channel's pending flag sets on a 0-to-1 transition of its source input. The flag stays set after the source falls. A source held high does not set the flag again after it has been cleared.
- R3: Reading 0x10 returns pending bits for channels 0 to 31, and reading 0x14 returns them for channels 32 to 39 in bits 7:0. Writing a 1 to a bit at either address clears that pending bit. Bits written as 0 are left unchanged.
- R4: Writing 1 to a bit at 0x20 or 0x24 enables that channel, and writing 1 to a bit at 0x30 or 0x34 disables it. Both use the same bank layout as R3, and zero bits are left unchanged. Reading any of these four addresses returns the enable mask of that bank.
- R5: From the edge after a primary channel becomes both pending and enabled, `irq_out` is 1. It stays 1 while any such channel exists, and it falls one edge after the last one goes away. A pending channel that is disabled never raises it.
- R6: Reading 0x40 returns, in bits 5:0, the lowest-numbered primary channel that is pending and enabled. It returns 0x3F when there is no such channel.
- R7: Each of the 32 secondary channels latches pending on a rising source edge. Reading 0x80 or 0x88 returns the secondary pending flags. A write of ones at 0x88 clears pending bits. A write of ones at 0x90 sets enables and a write of ones at 0x98 clears them. Reading 0x90 or 0x98 returns the secondary enable mask.
- R8: Primary channel 0 reads as pending exactly while some secondary channel is both pending and enabled. A write-1-to-clear on bit 0 at 0x10 has no effect on it.
- R9: Reading 0x200 + 4*i returns i for each primary channel i from 0 to 39. Reading 0x2A0 returns 0.
- R10: A read of any address not listed above returns 0.
- R11: When a rising source edge and a write-1-to-clear for the same channel are sampled at the same edge, the pending flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_src | input | 39 | Primary source lines for channels 1 to 39 (bit k is channel k) |
| sec_src | input | 32 | Secondary source lines, channels 0 to 31 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one edge after `rd_en` |
| irq_out | output | 1 | Registered request to the processor |

## Verification
The hardest case to reach is a rising source edge and a software clear that land on the same clock edge. The bench lowers a channel's source, then raises it again at the same clock phase at which the clear write is driven, and reads the flag back. The cascade needs a secondary flag that stays pending while its enable is toggled, which the bench arranges by holding one secondary source high. During that window it shows that clearing primary bit 0 does nothing and that only the secondary clear removes channel 0. A mid-run reset, applied while flags and enables are set, shows that reset really clears live state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Register byte offsets (bank n of a primary kind sits BANK_STRIDE*n above)
  localparam int OFS_PEND    = 'h010;
  localparam int OFS_ENSET   = 'h020;
  localparam int OFS_ENCLR   = 'h030;
  localparam int OFS_INDEX   = 'h040;
  localparam int OFS_SPEND   = 'h080;
  localparam int OFS_SCLR    = 'h088;
  localparam int OFS_SENSET  = 'h090;
  localparam int OFS_SENCLR  = 'h098;
  localparam int OFS_MAP     = 'h200;
  localparam int BANK_STRIDE = 4;
  localparam int MAP_STRIDE  = 4;
  localparam int IDX_W       = 6;
  localparam logic [IDX_W-1:0] IDX_NONE = '1;
endpackage

// File: rtl/edge_pend.sv
module edge_pend #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] src_q;
  logic [N-1:0] pend_q;

  // a fresh edge wins over a clear sampled at the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src;
      pend_q <= (pend_q & ~clr) | (src & ~src_q);
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/en_mask.sv
module en_mask #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_bits,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] en
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_bits) & ~clr_bits;
  end

  assign en = en_q;
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 40,
  parameter int IW = 6
) (
  input  logic [N-1:0]  act,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // scan from the top so the lowest active channel is assigned last
  always_comb begin
    hit = 1'b0;
    idx = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl #(
  parameter int NPRI = 40,
  parameter int NSEC = 32,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPRI-1:1] pri_src,
  input  logic [NSEC-1:0] sec_src,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_out
);
  import irq_pkg::*;

  localparam int PBANKS = (NPRI + DW - 1) / DW;
  localparam int PWIDE  = PBANKS * DW;

  logic [NPRI-1:1] p_clr;
  logic [NPRI-1:0] p_set, p_dis;
  logic [NSEC-1:0] s_clr, s_set, s_dis;
  logic [NPRI-1:1] pb_pend;
  logic [NPRI-1:0] pri_pend, pri_en;
  logic [NSEC-1:0] sec_pend, sec_en;
  logic            casc;
  logic            win_hit;
  logic [IDX_W-1:0] win_idx;

  // ---- write decode, one bit per primary channel ----
  for (genvar i = 0; i < NPRI; i++) begin : g_pdec
    if (i > 0) begin : g_clr
      assign p_clr[i] = wr_en && (addr == AW'(OFS_PEND + (i / DW) * BANK_STRIDE))
                        && wdata[i % DW];
    end
    assign p_set[i] = wr_en && (addr == AW'(OFS_ENSET + (i / DW) * BANK_STRIDE))
                      && wdata[i % DW];
    assign p_dis[i] = wr_en && (addr == AW'(OFS_ENCLR + (i / DW) * BANK_STRIDE))
                      && wdata[i % DW];
  end

  assign s_clr = (wr_en && addr == AW'(OFS_SCLR))   ? wdata[NSEC-1:0] : '0;
  assign s_set = (wr_en && addr == AW'(OFS_SENSET)) ? wdata[NSEC-1:0] : '0;
  assign s_dis = (wr_en && addr == AW'(OFS_SENCLR)) ? wdata[NSEC-1:0] : '0;

  // ---- secondary tier ----
  edge_pend #(.N(NSEC)) u_spend (
    .clk(clk), .rst(rst), .src(sec_src), .clr(s_clr), .pend(sec_pend)
  );
  en_mask #(.N(NSEC)) u_sen (
    .clk(clk), .rst(rst), .set_bits(s_set), .clr_bits(s_dis), .en(sec_en)
  );

  assign casc = |(sec_pend & sec_en);

  // ---- primary tier: channel 0 follows the cascade level ----
  edge_pend #(.N(NPRI - 1)) u_ppend (
    .clk(clk), .rst(rst), .src(pri_src), .clr(p_clr), .pend(pb_pend)
  );
  en_mask #(.N(NPRI)) u_pen (
    .clk(clk), .rst(rst), .set_bits(p_set), .clr_bits(p_dis), .en(pri_en)
  );

  assign pri_pend = {pb_pend, casc};

  prio_pick #(.N(NPRI), .IW(IDX_W)) u_pick (
    .act(pri_pend & pri_en), .hit(win_hit), .idx(win_idx)
  );

  // ---- read mux ----
  logic [PWIDE-1:0] pend_wide, en_wide;
  logic [AW-1:0]    map_off;
  logic [DW-1:0]    rword;

  assign pend_wide = PWIDE'(pri_pend);
  assign en_wide   = PWIDE'(pri_en);
  assign map_off   = addr - AW'(OFS_MAP);

  always_comb begin
    rword = '0;
    for (int b = 0; b < PBANKS; b++) begin
      if (addr == AW'(OFS_PEND + b * BANK_STRIDE))
        rword = pend_wide[b*DW +: DW];
      if (addr == AW'(OFS_ENSET + b * BANK_STRIDE) ||
          addr == AW'(OFS_ENCLR + b * BANK_STRIDE))
        rword = en_wide[b*DW +: DW];
    end
    if (addr == AW'(OFS_INDEX))
      rword = DW'(win_idx);
    if (addr == AW'(OFS_SPEND) || addr == AW'(OFS_SCLR))
      rword = DW'(sec_pend);
    if (addr == AW'(OFS_SENSET) || addr == AW'(OFS_SENCLR))
      rword = DW'(sec_en);
    if (addr >= AW'(OFS_MAP) && map_off < AW'(NPRI * MAP_STRIDE) && map_off[1:0] == 2'b00)
      rword = DW'(map_off >> 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_out <= 1'b0;
    end else begin
      if (rd_en) rdata <= rword;
      irq_out <= win_hit;
    end
  end
endmodule

// File: rtl/irq_chk.sv
module irq_chk #(
  parameter int NPRI = 40,
  parameter int NSEC = 32,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [NPRI-1:0] pri_pend,
  input logic [NPRI-1:0] pri_en,
  input logic [NSEC-1:0] sec_pend,
  input logic [NSEC-1:0] sec_en,
  input logic            win_hit,
  input logic [5:0]      win_idx,
  input logic            irq_out
);
  import irq_pkg::*;

  localparam int LOW = (NPRI < DW) ? NPRI : DW;

  logic [NPRI-1:0] act_c, below;
  assign act_c = pri_pend & pri_en;
  assign below = (NPRI'(1) << win_idx) - NPRI'(1);

  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_out == $past(|act_c));

  assert_idx_none_R6: assert property (@(posedge clk) disable iff (rst)
    !win_hit |-> win_idx == IDX_NONE);

  assert_idx_lowest_R6: assert property (@(posedge clk) disable iff (rst)
    win_hit |-> (((act_c >> win_idx) & NPRI'(1)) != '0) && ((act_c & below) == '0));

  assert_cascade_R8: assert property (@(posedge clk) disable iff (rst)
    pri_pend[0] == |(sec_pend & sec_en));

  assert_enset_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_ENSET)) |=>
      (pri_en[LOW-1:0] & $past(wdata[LOW-1:0])) == $past(wdata[LOW-1:0]));

  assert_enclr_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFS_ENCLR)) |=>
      (pri_en[LOW-1:0] & $past(wdata[LOW-1:0])) == '0);

  assert_pend_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == AW'(OFS_PEND)) |=>
      ($past(pri_pend[LOW-1:1]) & ~pri_pend[LOW-1:1]) == '0);
endmodule

bind casc_irq_ctrl irq_chk #(.NPRI(NPRI), .NSEC(NSEC), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pri_pend(pri_pend), .pri_en(pri_en), .sec_pend(sec_pend), .sec_en(sec_en),
  .win_hit(win_hit), .win_idx(win_idx), .irq_out(irq_out)
);

// File: tb/sim_casc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_casc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:1] psrc = '0;
  logic [31:0] ssrc = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;

  int n_chk = 0, n_err = 0;
  logic [31:0] got;

  casc_irq_ctrl u0 (
    .clk(clk), .rst(rst), .pri_src(psrc), .sec_src(ssrc),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_out(irq_out)
  );

  always #2 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [11:0] a;
    logic [31:0] d;
    logic [38:0] ps;   // bit k-1 drives channel k
    logic [31:0] ss;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 12'h040, 32'h0,  39'h0,           32'h0, 32'h3F}, // R1 idle index
    '{1'b0, 1'b0, 12'h000, 32'h0,  39'h1_0000_0010, 32'h0, 32'h0 }, // rise ch5, ch33
    '{1'b0, 1'b1, 12'h010, 32'h0,  39'h1_0000_0010, 32'h0, 32'h20}, // R2 ch5 latched
    '{1'b0, 1'b1, 12'h014, 32'h0,  39'h0,           32'h0, 32'h2 }, // R3 ch33 in bank 1
    '{1'b0, 1'b1, 12'h040, 32'h0,  39'h0,           32'h0, 32'h3F}, // R6 none enabled
    '{1'b1, 1'b0, 12'h024, 32'h2,  39'h0,           32'h0, 32'h0 }, // enable ch33
    '{1'b0, 1'b1, 12'h040, 32'h0,  39'h0,           32'h0, 32'd33}, // R6
    '{1'b1, 1'b0, 12'h020, 32'h20, 39'h0,           32'h0, 32'h0 }, // enable ch5
    '{1'b0, 1'b1, 12'h040, 32'h0,  39'h0,           32'h0, 32'd5 }, // R6 lowest wins
    '{1'b0, 1'b1, 12'h030, 32'h0,  39'h0,           32'h0, 32'h20}, // R4 mask readback
    '{1'b1, 1'b0, 12'h010, 32'h20, 39'h0,           32'h0, 32'h0 }, // clear ch5
    '{1'b0, 1'b1, 12'h010, 32'h0,  39'h0,           32'h0, 32'h0 }, // R3
    '{1'b0, 1'b1, 12'h040, 32'h0,  39'h0,           32'h0, 32'd33}, // R6
    '{1'b1, 1'b0, 12'h034, 32'h2,  39'h0,           32'h0, 32'h0 }, // disable ch33
    '{1'b0, 1'b1, 12'h024, 32'h0,  39'h0,           32'h0, 32'h0 }, // R4
    '{1'b0, 1'b1, 12'h040, 32'h0,  39'h0,           32'h0, 32'h3F}, // R6
    '{1'b0, 1'b1, 12'h014, 32'h0,  39'h0,           32'h0, 32'h2 }  // R3 still pending
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i].wr; rd_en = VEC[i].rd; addr = VEC[i].a; wdata = VEC[i].d;
      psrc = VEC[i].ps; ssrc = VEC[i].ss;
      @(negedge clk);
      if (VEC[i].rd) check($sformatf("table step %0d", i), rdata, VEC[i].exp);
    end
    wr_en = 1'b0; rd_en = 1'b0;

    // R1: reset while ch33 is pending and ch5 enabled
    do_reset();
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    rd(12'h014, got); check("R1 pending bank1", got, 32'h0);
    rd(12'h020, got); check("R1 enables", got, 32'h0);
    rd(12'h040, got); check("R1 index", got, 32'h3F);
    rd(12'h080, got); check("R1 sec pending", got, 32'h0);

    // R5: request timing
    wr(12'h020, 32'h80);
    psrc[7] = 1'b1;
    @(negedge clk); check("R5 one edge after rise", {31'b0, irq_out}, 32'h0);
    @(negedge clk); check("R5 asserted", {31'b0, irq_out}, 32'h1);
    psrc[7] = 1'b0;
    wr(12'h010, 32'h80);
    check("R5 held through clear edge", {31'b0, irq_out}, 32'h1);
    @(negedge clk); check("R5 released", {31'b0, irq_out}, 32'h0);
    psrc[9] = 1'b1;
    @(negedge clk); psrc[9] = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 disabled channel silent", {31'b0, irq_out}, 32'h0);

    // R11: edge and clear at the same edge on ch9
    psrc[9] = 1'b1;
    wr(12'h010, 32'h200);
    rd(12'h010, got); check("R11 edge beats clear", got, 32'h200);
    // R2: level held high does not re-latch
    wr(12'h010, 32'h200);
    @(negedge clk);
    rd(12'h010, got); check("R2 no relatch on level", got, 32'h0);
    psrc[9] = 1'b0;

    // R7 / R8: cascade through channel 0
    wr(12'h090, 32'h8);
    ssrc[3] = 1'b1;
    @(negedge clk);
    rd(12'h080, got); check("R7 sec pending", got, 32'h8);
    rd(12'h010, got); check("R8 channel 0 live", got, 32'h1);
    wr(12'h010, 32'h1);
    rd(12'h010, got); check("R8 clear on bit0 ignored", got, 32'h1);
    wr(12'h020, 32'h1);
    rd(12'h040, got); check("R6 cascade index", got, 32'h0);
    check("R5 cascade irq", {31'b0, irq_out}, 32'h1);
    rd(12'h098, got); check("R7 sec enable readback", got, 32'h8);
    wr(12'h098, 32'h8);
    rd(12'h010, got); check("R8 sec disabled", got, 32'h0);
    rd(12'h088, got); check("R7 sec still pending", got, 32'h8);
    wr(12'h090, 32'h8);
    wr(12'h088, 32'h8);
    rd(12'h080, got); check("R7 sec cleared", got, 32'h0);
    rd(12'h010, got); check("R8 channel 0 gone", got, 32'h0);
    ssrc[3] = 1'b0;

    // R9: identity table
    rd(12'h200, got); check("R9 entry 0", got, 32'd0);
    rd(12'h214, got); check("R9 entry 5", got, 32'd5);
    rd(12'h29C, got); check("R9 entry 39", got, 32'd39);
    rd(12'h2A0, got); check("R9 past end", got, 32'h0);

    // R10: unmapped addresses
    rd(12'h044, got); check("R10 0x44", got, 32'h0);
    rd(12'h018, got); check("R10 0x18", got, 32'h0);
    rd(12'h08C, got); check("R10 0x8C", got, 32'h0);
    rd(12'h300, got); check("R10 0x300", got, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule